// File: doc/BRIEF.md
# Multi-Master SCL Clock Synchronizer

This block drives the clock line of a two-wire serial bus that several masters share. The line is open-drain: it reads low whenever any master pulls it low, so the block never drives it high. The block only requests a pull-low. It counts its own low period and its own high period in system clock cycles. Its timing follows the line. The longest low period of any master sets the low phase, and the first master to finish its high period starts the next low phase for everyone.

The block takes a synchronously sampled copy of the line, an enable, and two period counts. It returns the pull-low request and two single-cycle strobes that mark line rising and line falling for a data-shifting engine. After the block releases the line, it waits until the line is actually seen high before it starts its high count. While it waits, another master may still be holding the line low. If the line drops while the block is counting high, the block drops its high count and starts a full low period of its own at once.

Top module: `sclClockSync`

## Requirements
- R1: During reset and while `enable` is low, `sclPullLow`, `sclRise` and `sclFall` are all 0, even if other masters toggle the line.
- R2: Each low phase driven by the block holds `sclPullLow` high for exactly L' consecutive cycles. L' is the latched low count, with 0 read as 1.
- R3: After the block releases the line, while the line stays low it keeps `sclPullLow` at 0, emits no `sclRise`, and does not count its high period.
- R4: When no other master interferes, `sclPullLow` is next asserted H'+1 cycles after the first cycle in which the line is high. H' is the latched high count, with 0 read as 1. One of those cycles is the sampling of the line.
- R5: If the line goes low while the block is counting high, `sclPullLow` is asserted in the next cycle, and then held for a full L' cycles.
- R6: A programmed count of 0 behaves exactly like a count of 1, for both the low and the high period.
- R7: Both counts are captured in the cycle after `enable` rises. Changes to `lowCount` or `highCount` while enabled have no effect.
- R8: `sclRise` is a one-cycle pulse. It appears one cycle after the line is first sampled high following a release, or following enable.
- R9: While enabled, `sclFall` is a one-cycle pulse. It appears one cycle after each sampled high-to-low change of the line.
- R10: Dropping `enable` releases the line in the same cycle, without waiting for a clock edge. Both counters are also cleared, so after re-enable on an idle line the first `sclPullLow` comes H'+2 cycles after `enable` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the clock generator; low releases the line |
| sclIn | input | 1 | Synchronized sample of the shared clock line |
| lowCount | input | CNT_W | Own low period in clock cycles (0 read as 1) |
| highCount | input | CNT_W | Own high period in clock cycles (0 read as 1) |
| sclPullLow | output | 1 | Request to pull the shared line low |
| sclRise | output | 1 | One-cycle strobe: line seen high after a low phase |
| sclFall | output | 1 | One-cycle strobe: line seen falling |

## Verification
All three outputs come from registers one edge after the sampled line changes. The one exception is the release on disable, which is combinational and is checked 1 ns after `enable` falls. The bench drives at the falling clock edge and samples at the falling clock edge before it drives. It counts run lengths in whole cycles: pull-low runs of L', line-high gaps of H'+1, a rise strobe at index 1 of the high gap, and a fall strobe at index 1 of the low phase. When a second master releases, the high gap is counted from the first falling edge at which the line reads high. A second master cutting in is expected to show up as `sclPullLow` and `sclFall` together exactly one cycle later.

// File: rtl/scl_sync_pkg.sv
package scl_sync_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_HIGH = 2'd2,
    ST_LOW  = 2'd3
  } sclState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture period counts
    logic clear;  // counter to zero
    logic start;  // counter to one (first cycle of a phase)
    logic inc;    // counter advance
  } cntCtl_t;

endpackage

// File: rtl/sclSyncDatapath.sv
module sclSyncDatapath
  import scl_sync_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntCtl_t          ctl,
  input  logic [CNT_W-1:0] lowCount,
  input  logic [CNT_W-1:0] highCount,
  input  logic             sclIn,
  output logic             lowDone,
  output logic             highDone,
  output logic             fallSeen
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] lowLat;
  logic [CNT_W-1:0] highLat;
  logic [CNT_W-1:0] phaseCnt;
  logic             sclPrev;

  // captured periods, zero promoted to one
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowLat  <= ONE;
      highLat <= ONE;
    end else if (ctl.load) begin
      lowLat  <= (lowCount  == '0) ? ONE : lowCount;
      highLat <= (highCount == '0) ? ONE : highCount;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (ctl.clear) begin
      phaseCnt <= '0;
    end else if (ctl.start) begin
      phaseCnt <= ONE;
    end else if (ctl.inc) begin
      phaseCnt <= phaseCnt + ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
    end else begin
      sclPrev <= sclIn;
    end
  end

  assign lowDone  = (phaseCnt == lowLat);
  assign highDone = (phaseCnt == highLat);
  assign fallSeen = sclPrev & ~sclIn;

endmodule

// File: rtl/sclSyncControl.sv
module sclSyncControl
  import scl_sync_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  logic    sclIn,
  input  logic    lowDone,
  input  logic    highDone,
  input  logic    fallSeen,
  output cntCtl_t ctl,
  output logic    pullQ,
  output logic    riseQ,
  output logic    fallQ
);

  sclState_e state;
  sclState_e stateNext;
  logic      pullNext;
  logic      riseNext;

  always_comb begin
    ctl       = '0;
    stateNext = state;
    pullNext  = pullQ;
    riseNext  = 1'b0;
    if (!enable) begin
      stateNext = ST_IDLE;
      pullNext  = 1'b0;
      ctl.clear = 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          ctl.load  = 1'b1;
          ctl.clear = 1'b1;
          pullNext  = 1'b0;
          stateNext = ST_WAIT;
        end
        ST_WAIT: begin
          // released; high count waits for the line itself
          if (sclIn) begin
            stateNext = ST_HIGH;
            ctl.start = 1'b1;
            riseNext  = 1'b1;
          end
        end
        ST_HIGH: begin
          if (!sclIn || highDone) begin
            stateNext = ST_LOW;
            pullNext  = 1'b1;
            ctl.start = 1'b1;
          end else begin
            ctl.inc = 1'b1;
          end
        end
        ST_LOW: begin
          if (lowDone) begin
            stateNext = ST_WAIT;
            pullNext  = 1'b0;
          end else begin
            ctl.inc = 1'b1;
          end
        end
        default: begin
          stateNext = ST_IDLE;
          pullNext  = 1'b0;
          ctl.clear = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      pullQ <= 1'b0;
      riseQ <= 1'b0;
      fallQ <= 1'b0;
    end else begin
      state <= stateNext;
      pullQ <= pullNext;
      riseQ <= riseNext;
      fallQ <= enable & fallSeen;
    end
  end

endmodule

// File: rtl/sclClockSync.sv
module sclClockSync
  import scl_sync_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             sclIn,
  input  logic [CNT_W-1:0] lowCount,
  input  logic [CNT_W-1:0] highCount,
  output logic             sclPullLow,
  output logic             sclRise,
  output logic             sclFall
);

  cntCtl_t ctl;
  logic    lowDone;
  logic    highDone;
  logic    fallSeen;
  logic    pullQ;

  sclSyncDatapath #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .lowCount  (lowCount),
    .highCount (highCount),
    .sclIn     (sclIn),
    .lowDone   (lowDone),
    .highDone  (highDone),
    .fallSeen  (fallSeen)
  );

  sclSyncControl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .sclIn    (sclIn),
    .lowDone  (lowDone),
    .highDone (highDone),
    .fallSeen (fallSeen),
    .ctl      (ctl),
    .pullQ    (pullQ),
    .riseQ    (sclRise),
    .fallQ    (sclFall)
  );

  // release is immediate on disable
  assign sclPullLow = pullQ & enable;

endmodule

// File: rtl/sclSyncChecker.sv
module sclSyncChecker (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic sclIn,
  input logic sclPullLow,
  input logic sclRise,
  input logic sclFall
);

  p_release_off_r10: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !sclPullLow);

  p_rise_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    sclRise |=> !sclRise);

  p_rise_line_high_r8: assert property (@(posedge clk) disable iff (!rstN)
    sclRise |-> ($past(sclIn) && !sclPullLow));

  p_fall_after_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    sclFall |-> !$past(sclIn));

  p_gap_after_release_r4: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && $fell(sclPullLow)) |=> !sclPullLow);

endmodule

bind sclClockSync sclSyncChecker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .enable     (enable),
  .sclIn      (sclIn),
  .sclPullLow (sclPullLow),
  .sclRise    (sclRise),
  .sclFall    (sclFall)
);

// File: tb/sclClockSync_tb.sv
module sclClockSync_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        enable;
  logic        otherLow;
  logic [15:0] lowCount;
  logic [15:0] highCount;
  logic        sclPullLow;
  logic        sclRise;
  logic        sclFall;
  logic        sclIn;
  int          total = 0;
  int          bad = 0;

  always #2.5 clk = ~clk;

  // wired-AND line: low if anyone pulls
  assign sclIn = ~(sclPullLow | otherLow);

  sclClockSync u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .sclIn      (sclIn),
    .lowCount   (lowCount),
    .highCount  (highCount),
    .sclPullLow (sclPullLow),
    .sclRise    (sclRise),
    .sclFall    (sclFall)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one solo period; counts may be changed right after enable
  task automatic runSolo(input int L, input int H, input int nL, input int nH, input string tag);
    int le = (L == 0) ? 1 : L;
    int he = (H == 0) ? 1 : H;
    int guard = 0;
    int lowLen = 0;
    int highLen = 0;
    int fallIdx = -1;
    int riseIdx = -1;
    int riseCnt = 0;
    enable = 1'b0;
    step();
    lowCount = 16'(L);
    highCount = 16'(H);
    enable = 1'b1;
    step();
    lowCount = 16'(nL);
    highCount = 16'(nH);
    while (!sclPullLow && guard < 200) begin step(); guard++; end
    while (sclPullLow && lowLen < 200) begin
      if (sclFall) fallIdx = lowLen;
      lowLen++;
      step();
    end
    while (!sclPullLow && highLen < 200) begin
      if (sclRise) begin riseCnt++; riseIdx = highLen; end
      if (sclFall && fallIdx < 0) fallIdx = lowLen + highLen;
      highLen++;
      step();
    end
    check(lowLen == le, {tag, " low run (R2/R6)"}, lowLen, le);
    check(highLen == he + 1, {tag, " high gap (R4/R6)"}, highLen, he + 1);
    check(riseCnt == 1 && riseIdx == 1, {tag, " rise index R8"}, riseIdx, 1);
    check(fallIdx == 1, {tag, " fall index R9"}, fallIdx, 1);
  endtask

  initial begin
    int guard;
    int cnt;
    int ones;
    int riseIdx;
    bit quiet;
    rstN = 1'b0;
    enable = 1'b0;
    otherLow = 1'b0;
    lowCount = '0;
    highCount = '0;
    repeat (3) step();
    check(!sclPullLow && !sclRise && !sclFall, "R1 reset outputs", {29'd0, sclPullLow, sclRise, sclFall}, 0);
    rstN = 1'b1;

    // R1: disabled, other master toggles the line
    quiet = 1'b1;
    for (int i = 0; i < 12; i++) begin
      otherLow = i[1];
      step();
      if (sclPullLow || sclRise || sclFall) quiet = 1'b0;
    end
    otherLow = 1'b0;
    check(quiet, "R1 disabled quiet", int'(quiet), 1);

    // R2 R4 R6 R8 R9: sweep of small period pairs
    for (int l = 0; l < 5; l++)
      for (int h = 0; h < 5; h++)
        runSolo(l, h, l, h, "sweep");

    // R7: counts changed after enable are ignored
    runSolo(2, 2, 9, 9, "latch R7");

    // R3: another master holds the line past own low period
    enable = 1'b0;
    step();
    lowCount = 16'd3;
    highCount = 16'd4;
    enable = 1'b1;
    guard = 0;
    while (!sclPullLow && guard < 200) begin step(); guard++; end
    otherLow = 1'b1;
    ones = 0;
    quiet = 1'b1;
    for (int k = 0; k < 8; k++) begin
      if (sclPullLow) ones++;
      if (k >= 3 && (sclPullLow || sclRise)) quiet = 1'b0;
      step();
    end
    check(ones == 3, "R2 low run under hold", ones, 3);
    check(quiet && !sclPullLow && !sclRise, "R3 wait while held", int'(quiet), 1);
    otherLow = 1'b0;
    cnt = 1;
    riseIdx = -1;
    while (cnt < 200) begin
      step();
      if (sclPullLow) break;
      if (sclRise) riseIdx = cnt;
      cnt++;
    end
    check(cnt == 5, "R3 high counted from line high", cnt, 5);
    check(riseIdx == 1, "R8 rise after hold", riseIdx, 1);

    // R5: another master cuts the high phase short
    enable = 1'b0;
    step();
    lowCount = 16'd3;
    highCount = 16'd6;
    enable = 1'b1;
    guard = 0;
    while (!sclPullLow && guard < 200) begin step(); guard++; end
    while (sclPullLow && guard < 400) begin step(); guard++; end
    step();
    step();
    otherLow = 1'b1;
    step();
    check(sclPullLow, "R5 pull next cycle", int'(sclPullLow), 1);
    check(sclFall, "R9 fall on foreign edge", int'(sclFall), 1);
    otherLow = 1'b0;
    ones = 0;
    while (sclPullLow && ones < 200) begin ones++; step(); end
    check(ones == 3, "R5 full own low after cut", ones, 3);

    // R10: disable releases at once, then restart timing
    guard = 0;
    while (!sclPullLow && guard < 200) begin step(); guard++; end
    enable = 1'b0;
    #1;
    check(!sclPullLow, "R10 immediate release", int'(sclPullLow), 0);
    quiet = 1'b1;
    for (int k = 0; k < 10; k++) begin
      step();
      if (sclPullLow) quiet = 1'b0;
    end
    check(quiet, "R10 stays released", int'(quiet), 1);
    lowCount = 16'd2;
    highCount = 16'd3;
    enable = 1'b1;
    cnt = 0;
    while (cnt < 200) begin
      step();
      cnt++;
      if (sclPullLow) break;
    end
    check(cnt == 5, "R10 first pull after enable", cnt, 5);

    enable = 1'b0;
    step();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule